// File: doc/BRIEF.md
# Segmented Modulation RAM Controller

This block owns a 1024-word by 32-bit modulation memory and plays it back into the control inputs of a numerically controlled oscillator. While playback is stopped, a host fills the memory through a plain address, data and write-strobe port. During playback the controller walks the addresses of one of four segments. Each segment has its own first and last address, its own dwell time in clocks and its own walking mode. The walking modes are one pass, endless loop and bounce between the two ends.

A destination select decides what the played word means to the oscillator. In frequency mode the whole word replaces the tuning word, and the oscillator keeps its own phase-offset register. In phase mode the oscillator keeps its own tuning register, and only the 14 most significant bits of the word are handed over as a phase offset. When the memory is switched off, the controller drives nothing, and the oscillator falls back on its own registers. A 2-bit profile input picks the segment. A new profile takes over at the next dwell boundary and starts at its segment's first address.

Top module: `modram_ctrl`

## Requirements
- R1: A host write (`hostWe`=1 while `playEn`=0) stores `hostData` at `hostAddr` in the 1024-word memory. The stored word comes back on `modWord` when playback presents that address.
- R2: Host writes made while `playEn`=1 are dropped, so the memory contents stay unchanged.
- R3: `modActive` is 1 exactly one clock after an edge at which both `ramEnable` and `playEn` were 1. Otherwise `modActive` and `modDest` are 0 and `modWord` is 0.
- R4: With `destPhase`=0 (frequency destination), `modDest`=0 and `modWord` carries the whole 32-bit memory word.
- R5: With `destPhase`=1 (phase destination), `modDest`=1 and `modWord` = {18 zero bits, word[31:18]}.
- R6: While stopped, the controller parks on the first address of the profiled segment. The output after the j-th clock edge of playback (j counted from 0) shows the word at step floor(j/(D+1)) of the walk, where D is the segment's dwell count.
- R7: Mode code 0 (one pass) and the spare code 3 walk upward from the first address to the last one, then hold the last word.
- R8: Mode code 1 (loop) walks upward and jumps from the last address back to the first.
- R9: Mode code 2 (bounce) walks up to the last address, then down to the first, and repeats without presenting either end twice in a row. A segment whose first and last addresses are equal holds that address.
- R10: A profile change is taken at the next dwell boundary. The output after that boundary edge still shows the old word. The new segment's first word appears one edge later and is held for its own dwell.
- R11: Segment i takes its first address from `segStart[10i+:10]`, its last address from `segEnd[10i+:10]`, its dwell from `segDwell[16i+:16]` and its mode from `segMode[2i+:2]`. Segments are configured independently, with first address <= last address, and stay stable while playback runs.
- R12: After reset, `modActive`=0, `modDest`=0 and `modWord`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 10 | Host write address |
| hostData | input | 32 | Host write data |
| ramEnable | input | 1 | Memory enabled; when 0 the outputs stay idle |
| playEn | input | 1 | Playback running |
| destPhase | input | 1 | Destination: 0 frequency, 1 phase offset |
| profile | input | 2 | Active segment select |
| segStart | input | 40 | Four packed 10-bit first addresses |
| segEnd | input | 40 | Four packed 10-bit last addresses |
| segDwell | input | 64 | Four packed 16-bit dwell counts |
| segMode | input | 8 | Four packed 2-bit walk modes |
| modWord | output | 32 | Word handed to the oscillator |
| modActive | output | 1 | Memory is driving the oscillator |
| modDest | output | 1 | 1 when the word is a phase offset |

## Verification
Every cycle, the assertions check the following rules. The address stays inside the active segment. The address holds between dwell boundaries. A one-pass walk parks on its last address. A loop wraps to its first address. The output valid flag follows the enable and play inputs with one clock of lag. The bench's scenarios are what show that the right words come out. They cover a readback of the whole memory, every mode under several dwell counts and segment sizes, both destinations, writes dropped during playback, and a profile switch landing on a dwell boundary.

// File: rtl/modram_pkg.sv
package modram_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_ONCE   = 2'd0,
    MODE_LOOP   = 2'd1,
    MODE_BOUNCE = 2'd2,
    MODE_SPARE  = 2'd3
  } walkMode_t;

  typedef struct packed {
    logic wrStb;
    logic actStb;
  } ctrlStrobe_t;
endpackage

// File: rtl/modram_seq.sv
module modram_seq
  import modram_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DWELL_W = 16,
  parameter int NUM_SEG = 4,
  localparam int SEG_W  = $clog2(NUM_SEG)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        playEn,
  input  logic                        ramEnable,
  input  logic                        hostWe,
  input  logic [SEG_W-1:0]            profile,
  input  logic [NUM_SEG*ADDR_W-1:0]   segStart,
  input  logic [NUM_SEG*ADDR_W-1:0]   segEnd,
  input  logic [NUM_SEG*DWELL_W-1:0]  segDwell,
  input  logic [NUM_SEG*MODE_W-1:0]   segMode,
  output logic [ADDR_W-1:0]           rdAddr,
  output ctrlStrobe_t                 strobe
);
  localparam logic [ADDR_W-1:0]  ADDR_ONE  = 1;
  localparam logic [DWELL_W-1:0] DWELL_ONE = 1;

  logic [ADDR_W-1:0]  startA [NUM_SEG];
  logic [ADDR_W-1:0]  endA   [NUM_SEG];
  logic [DWELL_W-1:0] dwellA [NUM_SEG];
  walkMode_t          modeA  [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : gUnpack
    assign startA[g] = segStart[g*ADDR_W +: ADDR_W];
    assign endA[g]   = segEnd[g*ADDR_W +: ADDR_W];
    assign dwellA[g] = segDwell[g*DWELL_W +: DWELL_W];
    assign modeA[g]  = walkMode_t'(segMode[g*MODE_W +: MODE_W]);
  end

  logic [SEG_W-1:0]   curSeg;
  logic [ADDR_W-1:0]  addr, nxtAddr;
  logic [DWELL_W-1:0] cnt;
  logic               goDown, nxtDown;

  logic [ADDR_W-1:0]  curStart, curEnd;
  logic [DWELL_W-1:0] curDwell;
  walkMode_t          curMode;
  logic               atBound;

  assign curStart = startA[curSeg];
  assign curEnd   = endA[curSeg];
  assign curDwell = dwellA[curSeg];
  assign curMode  = modeA[curSeg];
  assign atBound  = (cnt == curDwell);

  // next step of the walk inside the active segment
  always_comb begin
    nxtAddr = addr;
    nxtDown = goDown;
    case (curMode)
      MODE_LOOP: nxtAddr = (addr == curEnd) ? curStart : addr + ADDR_ONE;
      MODE_BOUNCE: begin
        if (curStart == curEnd) begin
          nxtAddr = addr;
        end else if (!goDown) begin
          if (addr == curEnd) begin
            nxtDown = 1'b1;
            nxtAddr = addr - ADDR_ONE;
          end else begin
            nxtAddr = addr + ADDR_ONE;
          end
        end else begin
          if (addr == curStart) begin
            nxtDown = 1'b0;
            nxtAddr = addr + ADDR_ONE;
          end else begin
            nxtAddr = addr - ADDR_ONE;
          end
        end
      end
      default: nxtAddr = (addr == curEnd) ? addr : addr + ADDR_ONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSeg <= '0;
      addr   <= '0;
      cnt    <= '0;
      goDown <= 1'b0;
    end else if (!playEn) begin
      curSeg <= profile;
      addr   <= startA[profile];
      cnt    <= '0;
      goDown <= 1'b0;
    end else if (atBound) begin
      cnt <= '0;
      if (profile != curSeg) begin
        curSeg <= profile;
        addr   <= startA[profile];
        goDown <= 1'b0;
      end else begin
        addr   <= nxtAddr;
        goDown <= nxtDown;
      end
    end else begin
      cnt <= cnt + DWELL_ONE;
    end
  end

  assign rdAddr        = addr;
  assign strobe.wrStb  = hostWe && !playEn;
  assign strobe.actStb = playEn && ramEnable;

  AST_ADDR_IN_SEG: assert property (@(posedge clk) disable iff (!rstN)
    (playEn && $past(playEn) && curStart <= curEnd) |-> (addr >= curStart && addr <= curEnd)); // R11

  AST_DWELL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (playEn && !atBound) |=> (addr == $past(addr))); // R6

  AST_ONCE_PARK: assert property (@(posedge clk) disable iff (!rstN)
    (playEn && (curMode inside {MODE_ONCE, MODE_SPARE}) && addr == curEnd && profile == curSeg)
      |=> (addr == $past(addr))); // R7

  AST_LOOP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (playEn && curMode == MODE_LOOP && addr == curEnd && atBound && profile == curSeg)
      |=> (addr == $past(curStart))); // R8
endmodule

// File: rtl/modram_store.sv
module modram_store
  import modram_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int PHASE_W = 14,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int PAD_W  = DATA_W - PHASE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              destPhase,
  output logic [DATA_W-1:0] modWord,
  output logic              modActive,
  output logic              modDest
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdWord;
  logic              actReg, destReg;

  always_ff @(posedge clk) begin
    if (strobe.wrStb) mem[wrAddr] <= wrData;
    rdWord <= mem[rdAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actReg  <= 1'b0;
      destReg <= 1'b0;
    end else begin
      actReg  <= strobe.actStb;
      destReg <= destPhase;
    end
  end

  always_comb begin
    if (!actReg)      modWord = '0;
    else if (destReg) modWord = {{PAD_W{1'b0}}, rdWord[DATA_W-1 -: PHASE_W]};
    else              modWord = rdWord;
  end

  assign modActive = actReg;
  assign modDest   = actReg && destReg;

  AST_OUT_ON: assert property (@(posedge clk) disable iff (!rstN)
    strobe.actStb |=> modActive); // R3

  AST_OUT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.actStb |=> (!modActive && !modDest && modWord == '0)); // R3
endmodule

// File: rtl/modram_ctrl.sv
module modram_ctrl
  import modram_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int DWELL_W = 16,
  parameter int PHASE_W = 14,
  parameter int NUM_SEG = 4,
  localparam int SEG_W  = $clog2(NUM_SEG)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostWe,
  input  logic [ADDR_W-1:0]          hostAddr,
  input  logic [DATA_W-1:0]          hostData,
  input  logic                       ramEnable,
  input  logic                       playEn,
  input  logic                       destPhase,
  input  logic [SEG_W-1:0]           profile,
  input  logic [NUM_SEG*ADDR_W-1:0]  segStart,
  input  logic [NUM_SEG*ADDR_W-1:0]  segEnd,
  input  logic [NUM_SEG*DWELL_W-1:0] segDwell,
  input  logic [NUM_SEG*MODE_W-1:0]  segMode,
  output logic [DATA_W-1:0]          modWord,
  output logic                       modActive,
  output logic                       modDest
);
  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] rdAddr;

  modram_seq #(.ADDR_W(ADDR_W), .DWELL_W(DWELL_W), .NUM_SEG(NUM_SEG)) uSeq (
    .clk(clk), .rstN(rstN), .playEn(playEn), .ramEnable(ramEnable), .hostWe(hostWe),
    .profile(profile), .segStart(segStart), .segEnd(segEnd), .segDwell(segDwell),
    .segMode(segMode), .rdAddr(rdAddr), .strobe(strobe)
  );

  modram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PHASE_W(PHASE_W)) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(hostAddr), .wrData(hostData),
    .rdAddr(rdAddr), .destPhase(destPhase), .modWord(modWord),
    .modActive(modActive), .modDest(modDest)
  );
endmodule

// File: tb/tb_modram_ctrl.sv
`timescale 1ns/1ps
module tb_modram_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [9:0]  hostAddr = '0;
  logic [31:0] hostData = '0;
  logic        ramEnable = 1'b0;
  logic        playEn = 1'b0;
  logic        destPhase = 1'b0;
  logic [1:0]  profile = '0;
  logic [39:0] segStart = '0;
  logic [39:0] segEnd = '0;
  logic [63:0] segDwell = '0;
  logic [7:0]  segMode = '0;
  logic [31:0] modWord;
  logic        modActive, modDest;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  modram_ctrl dut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr), .hostData(hostData),
    .ramEnable(ramEnable), .playEn(playEn), .destPhase(destPhase), .profile(profile),
    .segStart(segStart), .segEnd(segEnd), .segDwell(segDwell), .segMode(segMode),
    .modWord(modWord), .modActive(modActive), .modDest(modDest)
  );

  function automatic logic [31:0] wordOf(int a);
    logic [9:0] aa = a[9:0];
    return {aa, 4'h5, 8'h3C, aa};
  endfunction

  function automatic logic [31:0] shown(int a, bit ph);
    logic [31:0] w = wordOf(a);
    return ph ? {18'b0, w[31:18]} : w;
  endfunction

  function automatic int posOf(int mode, int s, int e, int n);
    int len = e - s;
    int m;
    if (mode == 1) return s + (n % (len + 1));
    if (mode == 2) begin
      if (len == 0) return s;
      m = n % (2 * len);
      return (m <= len) ? s + m : s + 2 * len - m;
    end
    return (s + n > e) ? e : s + n;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setSeg(int i, int s, int e, int d, int m);
    segStart[i*10 +: 10] = 10'(s);
    segEnd[i*10 +: 10]   = 10'(e);
    segDwell[i*16 +: 16] = 16'(d);
    segMode[i*2 +: 2]    = 2'(m);
  endtask

  // play segment seg for n edges and compare against the arithmetic walk
  task automatic playRun(int seg, int s, int e, int d, int m, bit ph, int n, string req);
    @(negedge clk);
    playEn = 1'b0; profile = 2'(seg); destPhase = ph;
    repeat (2) @(negedge clk);
    playEn = 1'b1;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      chk(req, modWord, shown(posOf(m, s, e, j / (d + 1)), ph));
      chk({req, " flags"}, {30'b0, modActive, modDest}, {30'b0, 1'b1, ph});
    end
    playEn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", {modWord[31:2], modActive, modDest}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12", {modWord[31:2], modActive, modDest}, 32'h0);

    // R1: fill the whole memory while stopped
    for (int a = 0; a < 1024; a++) begin
      hostWe = 1'b1; hostAddr = 10'(a); hostData = wordOf(a);
      @(negedge clk);
    end
    hostWe = 1'b0;
    ramEnable = 1'b1;

    // R1 R8: full readback in loop mode, dwell 0, with wrap
    for (int i = 0; i < 4; i++) setSeg(i, 700, 700, 0, 0);
    setSeg(0, 0, 1023, 0, 1);
    playRun(0, 0, 1023, 0, 1, 1'b0, 1030, "R1 R8");

    // R3: idle while stopped
    @(negedge clk);
    chk("R3 stopped", {modWord[31:2], modActive, modDest}, 32'h0);

    // R6 R7 R8 R9 R4 R5 R11: sweep modes, dwells and segment shapes
    begin
      int k = 0;
      int ss[4] = '{5, 10, 100, 1018};
      int ee[4] = '{5, 11, 104, 1023};
      int dd[3] = '{0, 1, 3};
      for (int m = 0; m < 4; m++)
        for (int di = 0; di < 3; di++)
          for (int p = 0; p < 4; p++) begin
            string tag;
            for (int i = 0; i < 4; i++) setSeg(i, 700, 702, 2, 1);
            setSeg(k % 4, ss[p], ee[p], dd[di], m);
            tag = (m == 1) ? "R6 R8 R11" : (m == 2) ? "R6 R9 R11" : "R6 R7 R11";
            playRun(k % 4, ss[p], ee[p], dd[di], m, bit'(k % 2), 40,
                    (k % 2) ? {tag, " R5"} : {tag, " R4"});
            k++;
          end
    end

    // R3: memory disabled while playing
    setSeg(0, 50, 60, 0, 1);
    ramEnable = 1'b0; profile = 2'd0;
    repeat (2) @(negedge clk);
    playEn = 1'b1;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      chk("R3 disabled", {modWord[31:2], modActive, modDest}, 32'h0);
    end
    playEn = 1'b0;
    ramEnable = 1'b1;
    @(negedge clk);

    // R2: writes during playback are dropped
    setSeg(0, 200, 203, 0, 1);
    destPhase = 1'b0;
    repeat (2) @(negedge clk);
    playEn = 1'b1;
    for (int j = 0; j < 16; j++) begin
      hostWe = 1'b1; hostAddr = 10'(200 + (j % 4)); hostData = 32'hDEADBEEF;
      @(negedge clk);
      chk("R2 during", modWord, wordOf(posOf(1, 200, 203, j)));
    end
    hostWe = 1'b0;
    playEn = 1'b0;
    @(negedge clk);
    playRun(0, 200, 203, 0, 1, 1'b0, 8, "R2 after");

    // R10: profile switch waits for the dwell boundary
    setSeg(0, 300, 309, 2, 1);
    setSeg(1, 400, 409, 1, 0);
    profile = 2'd0; destPhase = 1'b0;
    repeat (2) @(negedge clk);
    playEn = 1'b1;
    for (int j = 0; j < 30; j++) begin
      logic [31:0] exp;
      @(negedge clk);
      exp = (j <= 5) ? wordOf(posOf(1, 300, 309, j / 3))
                     : wordOf(posOf(0, 400, 409, (j - 6) / 2));
      chk("R10", modWord, exp);
      if (j == 4) profile = 2'd1;
    end
    playEn = 1'b0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule